// File: doc/BRIEF.md
# Parallel synchronous packet receiver

This block takes fixed-length packets from an external sender over a byte-wide parallel synchronous link. The sender provides the clock together with an 8-bit data bus, an enable line and a packet-start strobe. The block finds where each packet begins and counts bytes up to the configured length. It packs the bytes into 32-bit words and offers them to a downstream writer over a valid/ready handshake. One-cycle pulses report packets that completed and packets that were cut short by a fresh start.

A controller holds the `run` input low while it sets the packet length, then raises `run` to begin reception. For a few cycles after `run` rises, start strobes are not honoured while the configuration settles. The length setting is frozen for as long as `run` stays high. A packet opens only on a cycle where the start strobe and enable are high together. After that, enable does not matter until the next start. Packets may follow each other with no idle cycle between them.

Top module: `psync_pkt_rx`

## Requirements
- R1: A packet opens only on a cycle where `rx_start` and `rx_en` are both high while reception is live. A start with `rx_en` low is ignored, and the bytes after it produce no word and no `pkt_done`.
- R2: After a packet opens, `rx_en` has no effect. Exactly `cfg_len` bytes are accepted, counting the start byte. `pkt_done` is high for one cycle, in the cycle after the final byte is sampled.
- R3: A valid start sampled in the cycle right after the final byte of a packet opens a new packet.
- R4: Starts sampled in the first MASK_CYC cycles (default 4) with `run` high are ignored. The first start honoured can fall in cycle MASK_CYC+1.
- R5: `cfg_len` is captured only while `run` is low. A change made while `run` is high leaves the length in use unchanged. A value of 0 is treated as 1.
- R6: Byte k of a packet sits at bits 8*(k mod 4)+7 down to 8*(k mod 4) of its word, so the first byte is in bits 7:0. A word is offered once four bytes are collected. The final byte of a packet flushes a partial word, with zeros in the unused upper lanes.
- R7: A valid start while a packet is still open gives a one-cycle `pkt_abort` pulse and discards the partial lanes not yet offered. A new packet is then counted from that start byte. Words already offered are kept. `pkt_abort` and `pkt_done` are never high together.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays stable. A word that completes while an earlier word is held and not taken is discarded.
- R9: After reset, `out_valid`, `pkt_done` and `pkt_abort` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock from the sender |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Receiver on; configuration captured while low |
| cfg_len | input | 12 | Packet length in bytes |
| rx_data | input | 8 | Received byte |
| rx_en | input | 1 | Sender enable line |
| rx_start | input | 1 | Packet-start strobe, marks the first byte |
| out_ready | input | 1 | Downstream accepts the offered word |
| out_valid | output | 1 | A packed word is offered |
| out_data | output | 32 | Packed word, first byte in bits 7:0 |
| pkt_done | output | 1 | One-cycle pulse: packet completed |
| pkt_abort | output | 1 | One-cycle pulse: open packet cut by a new start |

## Verification
The bench places a start on the last masked cycle and on the first live cycle. A receiver with an off-by-one mask would either lose the good packet or accept the bad one. It changes the length while running; a design that picked up the change would end the packet early, lose its tail and report the wrong number of words. It sends back-to-back packets that drop enable after the start, so a receiver that needs a gap, or that keys on enable, would miss the second packet or truncate the first. It also cuts a packet with a new start, uses a length that is not a multiple of four, and stalls the downstream. These catch a missing abort pulse, stale bytes leaking into the upper lanes, and an offered word that changes or is overwritten while held.

// File: rtl/pkt_rx_pkg.sv
package pkt_rx_pkg;
    localparam int BYTE_W  = 8;
    localparam int WORD_W  = 32;
    localparam int LANES   = WORD_W / BYTE_W;
    localparam int LANE_W  = $clog2(LANES);
    localparam int LEN_W   = 12;
    localparam int DEF_LEN = 256;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [LEN_W-1:0]  len_t;
    typedef logic [LANE_W-1:0] lane_t;

    typedef struct packed {
        logic  acc;
        logic  first;
        logic  last;
        byte_t data;
    } byte_evt_t;

    function automatic len_t clamp_len(input len_t raw);
        return (raw == '0) ? len_t'(1) : raw;
    endfunction

    function automatic word_t put_lane(input word_t base, input lane_t idx, input byte_t b);
        word_t w;
        w = base;
        w[idx*BYTE_W +: BYTE_W] = b;
        return w;
    endfunction
endpackage

// File: rtl/pkt_rx_gate.sv
module pkt_rx_gate
    import pkt_rx_pkg::*;
#(
    parameter int MASK_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  len_t cfg_len,
    output logic live,
    output len_t len_q
);
    localparam int MW = $clog2(MASK_CYC + 2);
    localparam logic [MW-1:0] MASK_LIM = MW'(MASK_CYC);

    logic [MW-1:0] mcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            mcnt  <= '0;
            len_q <= len_t'(DEF_LEN);
        end else if (!run) begin
            mcnt  <= '0;
            len_q <= clamp_len(cfg_len);
        end else if (mcnt != MASK_LIM) begin
            mcnt <= mcnt + 1'b1;
        end
    end

    assign live = run && (mcnt == MASK_LIM);

    // R4
    mask_window_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(run) |-> !live);

    // R5
    cfg_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run)) |-> $stable(len_q));
endmodule

// File: rtl/pkt_rx_framer.sv
module pkt_rx_framer
    import pkt_rx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      live,
    input  len_t      len_q,
    input  byte_t     rx_data,
    input  logic      rx_en,
    input  logic      rx_start,
    output byte_evt_t evt,
    output logic      pkt_done,
    output logic      pkt_abort
);
    logic active;
    len_t cnt;
    logic start_ok;

    assign start_ok = live && rx_start && rx_en;

    always_comb begin
        evt.acc   = live && (start_ok || active);
        evt.first = start_ok;
        evt.last  = start_ok ? (len_q == len_t'(1)) : (cnt == len_q - len_t'(1));
        evt.data  = rx_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active    <= 1'b0;
            cnt       <= '0;
            pkt_done  <= 1'b0;
            pkt_abort <= 1'b0;
        end else begin
            pkt_done  <= evt.acc && evt.last;
            pkt_abort <= start_ok && active;
            if (!live) begin
                active <= 1'b0;
                cnt    <= '0;
            end else if (start_ok) begin
                active <= (len_q != len_t'(1));
                cnt    <= len_t'(1);
            end else if (active) begin
                cnt <= cnt + len_t'(1);
                if (evt.last) active <= 1'b0;
            end
        end
    end

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        active |-> (cnt < len_q));

    // R7
    done_abort_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(pkt_done && pkt_abort));
endmodule

// File: rtl/pkt_rx_packer.sv
module pkt_rx_packer
    import pkt_rx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  byte_evt_t evt,
    input  logic      out_ready,
    output logic      out_valid,
    output word_t     out_data
);
    localparam lane_t LAST_LANE = lane_t'(LANES - 1);

    word_t word_q;
    lane_t lane_q;
    word_t base;
    lane_t lane;
    word_t nxt;
    logic  emit;

    always_comb begin
        base = evt.first ? '0 : word_q;
        lane = evt.first ? '0 : lane_q;
        nxt  = put_lane(base, lane, evt.data);
        emit = evt.acc && ((lane == LAST_LANE) || evt.last);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q    <= '0;
            lane_q    <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            if (evt.acc) begin
                if (emit) begin
                    word_q <= '0;
                    lane_q <= '0;
                end else begin
                    word_q <= nxt;
                    lane_q <= lane + 1'b1;
                end
            end
            if (emit && (!out_valid || out_ready)) begin
                out_valid <= 1'b1;
                out_data  <= nxt;
            end else if (out_ready) begin
                out_valid <= 1'b0;
            end
        end
    end

    // R8
    hold_word_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/psync_pkt_rx.sv
module psync_pkt_rx
    import pkt_rx_pkg::*;
#(
    parameter int MASK_CYC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_en,
    input  logic              rx_start,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    output logic              pkt_done,
    output logic              pkt_abort
);
    logic      live;
    len_t      len_q;
    byte_evt_t evt;

    pkt_rx_gate #(.MASK_CYC(MASK_CYC)) u_gate (
        .clk(clk), .rst(rst), .run(run), .cfg_len(cfg_len),
        .live(live), .len_q(len_q)
    );

    pkt_rx_framer u_framer (
        .clk(clk), .rst(rst), .live(live), .len_q(len_q),
        .rx_data(rx_data), .rx_en(rx_en), .rx_start(rx_start),
        .evt(evt), .pkt_done(pkt_done), .pkt_abort(pkt_abort)
    );

    pkt_rx_packer u_packer (
        .clk(clk), .rst(rst), .evt(evt), .out_ready(out_ready),
        .out_valid(out_valid), .out_data(out_data)
    );

    // R1
    no_start_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && !$past(run)) |-> !pkt_done);
endmodule

// File: tb/tb_psync_pkt_rx.sv
module tb_psync_pkt_rx;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run = 1'b0;
    logic [11:0] cfg_len = 12'd16;
    logic [7:0]  rx_data = 8'h00;
    logic        rx_en = 1'b0;
    logic        rx_start = 1'b0;
    logic        out_ready = 1'b1;
    logic        out_valid;
    logic [31:0] out_data;
    logic        pkt_done;
    logic        pkt_abort;

    int checks_n = 0;
    int fails_n  = 0;
    int rx_n = 0, exp_n = 0, done_n = 0, abort_n = 0;
    logic [31:0] rx_w  [0:511];
    logic [31:0] exp_w [0:511];
    bit finished = 1'b0;

    localparam int NV = 5;
    localparam int VLEN  [NV] = '{256, 16, 6, 1, 12};
    localparam int VMODE [NV] = '{0, 1, 0, 1, 1};

    psync_pkt_rx dut (
        .clk(clk), .rst(rst), .run(run), .cfg_len(cfg_len),
        .rx_data(rx_data), .rx_en(rx_en), .rx_start(rx_start),
        .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
        .pkt_done(pkt_done), .pkt_abort(pkt_abort)
    );

    always #10 clk = ~clk;

    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid && out_ready && rx_n < 512) begin
                rx_w[rx_n] = out_data;
                rx_n++;
            end
            if (pkt_done)  done_n++;
            if (pkt_abort) abort_n++;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks_n++;
        if (!ok) begin
            fails_n++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_counts();
        rx_n = 0; exp_n = 0; done_n = 0; abort_n = 0;
    endtask

    // mode 0: enable over whole packet, 1: enable on start byte only, 2: enable never
    task automatic send_bytes(input logic [7:0] seed, input int n, input int mode);
        for (int i = 0; i < n; i++) begin
            rx_data  = seed + 8'(i);
            rx_start = (i == 0);
            rx_en    = (mode == 0) ? 1'b1 : (mode == 1) ? (i == 0) : 1'b0;
            @(negedge clk);
        end
        rx_start = 1'b0;
        rx_en    = 1'b0;
    endtask

    task automatic exp_bytes(input logic [7:0] seed, input int n, input bit flush);
        int nw;
        nw = flush ? (n + 3) / 4 : n / 4;
        for (int w = 0; w < nw; w++) begin
            logic [31:0] x;
            x = '0;
            for (int b = 0; b < 4; b++)
                if (4 * w + b < n) x[8*b +: 8] = seed + 8'(4 * w + b);
            exp_w[exp_n] = x;
            exp_n++;
        end
    endtask

    task automatic verify(input string tag);
        chk(rx_n == exp_n, $sformatf("%s word count", tag), 32'(rx_n), 32'(exp_n));
        for (int i = 0; i < exp_n && i < rx_n; i++)
            chk(rx_w[i] == exp_w[i], $sformatf("%s word %0d", tag, i), rx_w[i], exp_w[i]);
    endtask

    task automatic configure(input int len);
        run = 1'b0;
        cfg_len = 12'(len);
        idle(2);
        run = 1'b1;
        idle(4);
    endtask

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);
        // R9 reset state
        chk(out_valid == 1'b0, "R9 out_valid after reset", 32'(out_valid), 0);
        chk(pkt_done == 1'b0, "R9 pkt_done after reset", 32'(pkt_done), 0);
        chk(pkt_abort == 1'b0, "R9 pkt_abort after reset", 32'(pkt_abort), 0);

        // R2 R6 table walk over lengths and enable patterns
        for (int v = 0; v < NV; v++) begin
            logic [7:0] seed;
            seed = 8'(8'h20 * v + 3);
            configure(VLEN[v]);
            clear_counts();
            send_bytes(seed, VLEN[v], VMODE[v]);
            exp_bytes(seed, VLEN[v], 1'b1);
            idle(4);
            chk(done_n == 1, $sformatf("R2 vec %0d done pulses", v), 32'(done_n), 1);
            chk(abort_n == 0, $sformatf("R7 vec %0d no abort", v), 32'(abort_n), 0);
            verify($sformatf("R6 vec %0d", v));
        end

        // R1 start with enable low ignored
        configure(8);
        clear_counts();
        send_bytes(8'h50, 8, 2);
        idle(4);
        chk(done_n == 0, "R1 enable-low start done", 32'(done_n), 0);
        chk(rx_n == 0, "R1 enable-low start words", 32'(rx_n), 0);

        // R4 start in last masked cycle ignored, first live cycle honoured
        run = 1'b0; cfg_len = 12'd4; idle(2);
        clear_counts();
        run = 1'b1; idle(3);
        send_bytes(8'h60, 4, 0);
        idle(4);
        chk(done_n == 0, "R4 masked start done", 32'(done_n), 0);
        chk(rx_n == 0, "R4 masked start words", 32'(rx_n), 0);
        run = 1'b0; idle(2);
        run = 1'b1; idle(4);
        send_bytes(8'h70, 4, 0);
        exp_bytes(8'h70, 4, 1'b1);
        idle(4);
        chk(done_n == 1, "R4 first live start done", 32'(done_n), 1);
        verify("R4 first live start");

        // R5 length change while running ignored
        configure(16);
        clear_counts();
        cfg_len = 12'd8;
        idle(2);
        send_bytes(8'h80, 16, 0);
        exp_bytes(8'h80, 16, 1'b1);
        idle(4);
        chk(done_n == 1, "R5 locked length done", 32'(done_n), 1);
        verify("R5 locked length");

        // R7 new start cuts open packet
        configure(16);
        clear_counts();
        send_bytes(8'h90, 6, 0);
        send_bytes(8'hA0, 16, 1);
        exp_bytes(8'h90, 6, 1'b0);
        exp_bytes(8'hA0, 16, 1'b1);
        idle(4);
        chk(abort_n == 1, "R7 abort pulses", 32'(abort_n), 1);
        chk(done_n == 1, "R7 done after restart", 32'(done_n), 1);
        verify("R7 restart");

        // R3 back-to-back packets, enable dropped after start
        configure(8);
        clear_counts();
        send_bytes(8'hB0, 8, 1);
        send_bytes(8'hC0, 8, 1);
        exp_bytes(8'hB0, 8, 1'b1);
        exp_bytes(8'hC0, 8, 1'b1);
        idle(4);
        chk(done_n == 2, "R3 back-to-back done", 32'(done_n), 2);
        chk(abort_n == 0, "R3 back-to-back no abort", 32'(abort_n), 0);
        verify("R3 back-to-back");

        // R8 held word stable under stall, later word dropped
        configure(8);
        clear_counts();
        out_ready = 1'b0;
        send_bytes(8'hD0, 8, 0);
        idle(2);
        chk(out_valid == 1'b1, "R8 held valid", 32'(out_valid), 1);
        chk(out_data == 32'hD3D2D1D0, "R8 held data", out_data, 32'hD3D2D1D0);
        idle(5);
        chk(out_data == 32'hD3D2D1D0, "R8 held data later", out_data, 32'hD3D2D1D0);
        out_ready = 1'b1;
        idle(3);
        exp_bytes(8'hD0, 4, 1'b1);
        verify("R8 stall");
        chk(out_valid == 1'b0, "R8 drained", 32'(out_valid), 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks_n - fails_n, checks_n);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks_n++;
            fails_n++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("%0d/%0d checks passed", checks_n - fails_n, checks_n);
            $finish;
        end
    end
endmodule